// File: doc/BRIEF.md
# Power Controller Request and Completion Unit

This block sits on a simple register bus and accepts three kinds of work: a performance-level change for cluster 0, a performance-level change for cluster 1, and a read from a configuration space. Only one request is in flight at a time. A back end with a fixed, parameterised latency services each request. It either accepts the request or rejects it. A rejected level leaves the cluster's level untouched. A rejected configuration read leaves the read-data register untouched.

The outcome of each request is written to a sticky status word. Each request type owns one nibble of that word: the completion flag sits at bit 4*t and the error flag at bit 4*t+1. An active-high, level-sensitive interrupt stays asserted while any status bit is set. Reading the status word returns its value and clears it. The block also holds a wake-up mask register. It also presents a read-only standby status word built from per-CPU standby inputs.

Top module: `pwr_req_ctrl`

## Requirements
- R1: After reset, both cluster levels read 0, the status word reads 0, the wake-up mask reads 0 and `irq_o` is low.
- R2: A write of value v to the cluster-0 level register (0x00) or the cluster-1 level register (0x04) starts a request of type 0 or type 1. When v < NUM_LEVELS, LATENCY cycles later status bit 0 (type 0) or bit 4 (type 1) is set, and that level register reads back v.
- R3: When v >= NUM_LEVELS, status bit 1 (type 0) or bit 5 (type 1) is set instead, and the level register keeps its previous value.
- R4: A write to the command register (0x08) with bit 31 set starts a type-2 request. The function code is in bits 23:20, bits 30:24 must be 0, and the word offset is in bits 19:0. For function 6 and an offset o with CFG_BASE <= o < CFG_BASE+CFG_DEPTH, status bit 8 is set. Register 0x0C then holds entry i = o-CFG_BASE, whose value is ((800+25*i) << 20) | (10000+2500*i).
- R5: A command with another function code, nonzero bits 30:24, or an offset outside the table sets status bit 9 instead, and register 0x0C keeps its value.
- R6: A command write with bit 31 clear starts nothing: status stays 0 and the interrupt stays low.
- R7: A read of the status register (0x10) returns the accumulated bits and clears them, so `irq_o` falls on the next cycle unless a completion lands in that same cycle.
- R8: `irq_o` is high while any status bit is set. Bits from successive requests accumulate until the status word is read.
- R9: A request written while another is pending is ignored: it changes neither the status nor the level it targets.
- R10: The wake-up mask register (0x14) is a 12-bit read/write register. Cluster-0 CPUs use bits 3:0, cluster-1 CPUs use bits 9:4 and the global wake-up uses bits 11:10. Higher bits read 0.
- R11: The standby register (0x18) reads cluster-0 CPU n standby at bit n and cluster-1 CPU n standby at bit 3+n.
- R12: Reads of the command register and of any unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| cl0_standby | input | CL0_CPUS | Per-CPU standby flags, cluster 0 |
| cl1_standby | input | CL1_CPUS | Per-CPU standby flags, cluster 1 |
| irq_o | output | 1 | Level interrupt, high while status is nonzero |

## Verification
The bench builds the block with LATENCY=3, NUM_LEVELS=8, a 16-entry configuration table based at word offset 0x304, three cluster-0 CPUs and two cluster-1 CPUs. With a short latency, a second request can be written while the first is still pending, and a status read can be made right after a completion. Level 7 and level 8 fall on either side of the level limit. Offsets 0x303, 0x304, 0x313 and 0x314 probe both edges of the table.

// File: rtl/pwr_req_pkg.sv
package pwr_req_pkg;

  typedef enum logic [1:0] {
    RT_CL0 = 2'd0,
    RT_CL1 = 2'd1,
    RT_CFG = 2'd2
  } req_type_e;

  typedef enum logic [2:0] {
    RS_LVL0, RS_LVL1, RS_CMD, RS_RDATA, RS_STAT, RS_WAKE, RS_STBY, RS_NONE
  } rsel_e;

  localparam logic [3:0] FUNC_CLKCTL = 4'd6;

  // status bit index owned by a request type and outcome
  function automatic int unsigned stat_bit(req_type_e t, logic err);
    return 4 * int'(t) + (err ? 1 : 0);
  endfunction

  // computed configuration table entry: millivolts high, frequency code low
  function automatic logic [31:0] cfg_entry(logic [19:0] idx);
    logic [31:0] mv;
    logic [31:0] khz;
    mv  = 32'd800 + 32'd25 * 32'(idx);
    khz = 32'd10000 + 32'd2500 * 32'(idx);
    return {mv[11:0], khz[19:0]};
  endfunction

endpackage

// File: rtl/pwr_req_decode.sv
module pwr_req_decode
  import pwr_req_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output rsel_e         rsel,
  output logic          wr_lvl0,
  output logic          wr_lvl1,
  output logic          wr_cmd,
  output logic          wr_wake,
  output logic          rd_stat
);

  always_comb begin
    case (addr)
      AW'('h00): rsel = RS_LVL0;
      AW'('h04): rsel = RS_LVL1;
      AW'('h08): rsel = RS_CMD;
      AW'('h0C): rsel = RS_RDATA;
      AW'('h10): rsel = RS_STAT;
      AW'('h14): rsel = RS_WAKE;
      AW'('h18): rsel = RS_STBY;
      default:   rsel = RS_NONE;
    endcase
  end

  assign wr_lvl0 = sel && wr && (rsel == RS_LVL0);
  assign wr_lvl1 = sel && wr && (rsel == RS_LVL1);
  assign wr_cmd  = sel && wr && (rsel == RS_CMD);
  assign wr_wake = sel && wr && (rsel == RS_WAKE);
  assign rd_stat = sel && !wr && (rsel == RS_STAT);

endmodule

// File: rtl/pwr_req_cfgrom.sv
module pwr_req_cfgrom
  import pwr_req_pkg::*;
#(
  parameter int CFG_BASE  = 'h304,
  parameter int CFG_DEPTH = 16
) (
  input  logic [31:0] cmd,
  output logic        hit,
  output logic [31:0] data
);

  localparam logic [19:0] LO = 20'(CFG_BASE);
  localparam logic [19:0] HI = 20'(CFG_BASE + CFG_DEPTH);

  logic [19:0] off;
  logic [19:0] idx;

  assign off  = cmd[19:0];
  assign idx  = off - LO;
  assign hit  = cmd[31] && (cmd[30:24] == 7'd0) && (cmd[23:20] == FUNC_CLKCTL)
                && (off >= LO) && (off < HI);
  assign data = cfg_entry(idx);

endmodule

// File: rtl/pwr_req_engine.sv
module pwr_req_engine
  import pwr_req_pkg::*;
#(
  parameter int LATENCY    = 4,
  parameter int NUM_LEVELS = 8,
  parameter int CFG_BASE   = 'h304,
  parameter int CFG_DEPTH  = 16,
  localparam int LW = $clog2(NUM_LEVELS),
  localparam int CW = $clog2(LATENCY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lvl0,
  input  logic          wr_lvl1,
  input  logic          wr_cmd,
  input  logic [31:0]   wdata,
  output logic          req_accept,
  output logic          busy,
  output logic          done_ev,
  output req_type_e     done_type,
  output logic          done_err,
  output logic [LW-1:0] lvl0,
  output logic [LW-1:0] lvl1,
  output logic [31:0]   cfg_rdata
);

  logic          req_any;
  req_type_e     req_type;
  logic [CW-1:0] cnt_q;
  logic [31:0]   arg_q;
  logic          rom_hit;
  logic [31:0]   rom_data;
  logic          lvl_bad;

  assign req_any  = wr_lvl0 || wr_lvl1 || (wr_cmd && wdata[31]);
  assign req_type = wr_lvl0 ? RT_CL0 : (wr_lvl1 ? RT_CL1 : RT_CFG);
  assign req_accept = req_any && !busy;

  pwr_req_cfgrom #(.CFG_BASE(CFG_BASE), .CFG_DEPTH(CFG_DEPTH)) rom_i (
    .cmd  (arg_q),
    .hit  (rom_hit),
    .data (rom_data)
  );

  assign lvl_bad  = (arg_q >= 32'(NUM_LEVELS));
  assign done_ev  = busy && (cnt_q == '0);
  assign done_err = (done_type == RT_CFG) ? !rom_hit : lvl_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt_q     <= '0;
      arg_q     <= '0;
      done_type <= RT_CL0;
    end else if (req_accept) begin
      busy      <= 1'b1;
      cnt_q     <= CW'(LATENCY - 1);
      arg_q     <= wdata;
      done_type <= req_type;
    end else if (done_ev) begin
      busy      <= 1'b0;
    end else if (busy) begin
      cnt_q     <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl0      <= '0;
      lvl1      <= '0;
      cfg_rdata <= '0;
    end else if (done_ev && !done_err) begin
      case (done_type)
        RT_CL0:  lvl0      <= arg_q[LW-1:0];
        RT_CL1:  lvl1      <= arg_q[LW-1:0];
        default: cfg_rdata <= rom_data;
      endcase
    end
  end

endmodule

// File: rtl/pwr_req_ctrl.sv
module pwr_req_ctrl
  import pwr_req_pkg::*;
#(
  parameter int AW         = 8,
  parameter int LATENCY    = 4,
  parameter int NUM_LEVELS = 8,
  parameter int CFG_BASE   = 'h304,
  parameter int CFG_DEPTH  = 16,
  parameter int CL0_CPUS   = 3,
  parameter int CL1_CPUS   = 2,
  parameter int WAKE_W     = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [CL0_CPUS-1:0] cl0_standby,
  input  logic [CL1_CPUS-1:0] cl1_standby,
  output logic                irq_o
);

  localparam int LVL_W = $clog2(NUM_LEVELS);
  localparam int STW   = 12;

  rsel_e             rsel;
  logic              wr_lvl0, wr_lvl1, wr_cmd, wr_wake, rd_stat;
  logic              req_accept, busy, done_ev, done_err;
  req_type_e         done_type;
  logic [LVL_W-1:0]  lvl0, lvl1;
  logic [31:0]       cfg_rdata;
  logic [STW-1:0]    stat_q;
  logic [STW-1:0]    stat_set;
  logic [WAKE_W-1:0] wake_q;

  pwr_req_decode #(.AW(AW)) dec_i (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .rsel(rsel),
    .wr_lvl0(wr_lvl0), .wr_lvl1(wr_lvl1), .wr_cmd(wr_cmd),
    .wr_wake(wr_wake), .rd_stat(rd_stat)
  );

  pwr_req_engine #(
    .LATENCY(LATENCY), .NUM_LEVELS(NUM_LEVELS),
    .CFG_BASE(CFG_BASE), .CFG_DEPTH(CFG_DEPTH)
  ) eng_i (
    .clk(clk), .rst_n(rst_n),
    .wr_lvl0(wr_lvl0), .wr_lvl1(wr_lvl1), .wr_cmd(wr_cmd), .wdata(bus_wdata),
    .req_accept(req_accept), .busy(busy), .done_ev(done_ev),
    .done_type(done_type), .done_err(done_err),
    .lvl0(lvl0), .lvl1(lvl1), .cfg_rdata(cfg_rdata)
  );

  always_comb begin
    stat_set = '0;
    if (done_ev) stat_set[stat_bit(done_type, done_err)] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (rd_stat ? '0 : stat_q) | stat_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wake_q <= '0;
    else if (wr_wake) wake_q <= bus_wdata[WAKE_W-1:0];
  end

  assign irq_o = |stat_q;

  always_comb begin
    case (rsel)
      RS_LVL0:  bus_rdata = 32'(lvl0);
      RS_LVL1:  bus_rdata = 32'(lvl1);
      RS_RDATA: bus_rdata = cfg_rdata;
      RS_STAT:  bus_rdata = 32'(stat_q);
      RS_WAKE:  bus_rdata = 32'(wake_q);
      RS_STBY:  bus_rdata = 32'({cl1_standby, cl0_standby});
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pwr_req_ctrl_chk.sv
module pwr_req_ctrl_chk #(
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_accept,
  input logic          busy,
  input logic          done_ev,
  input logic          rd_stat,
  input logic          irq_o,
  input logic [LW-1:0] lvl0,
  input logic [LW-1:0] lvl1
);

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> busy);

  assert_done_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> !busy);

  assert_done_raises_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> irq_o);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !done_ev) |=> !irq_o);

  assert_levels_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_ev) |=> ($stable(lvl0) && $stable(lvl1)));

endmodule

bind pwr_req_ctrl pwr_req_ctrl_chk #(.LW(LVL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_accept(req_accept), .busy(busy),
  .done_ev(done_ev), .rd_stat(rd_stat), .irq_o(irq_o),
  .lvl0(lvl0), .lvl1(lvl1)
);

// File: tb/pwr_req_ctrl_tb_top.sv
module pwr_req_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int WDOG       = 20000;

  localparam logic [7:0] A_L0 = 8'h00, A_L1 = 8'h04, A_CMD = 8'h08, A_RD = 8'h0C,
                         A_ST = 8'h10, A_WK = 8'h14, A_SB = 8'h18;

  function automatic logic [31:0] entry(int i);
    int mv;
    int fr;
    mv = 800 + 25 * i;
    fr = 10000 + 2500 * i;
    return (32'(mv) << 20) + 32'(fr);
  endfunction

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [11:0] exp_stat;
    logic [7:0]  rb_addr;
    logic [31:0] exp_rb;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{A_L0,  32'd3,          12'h001, A_L0, 32'd3,      4'd2},  // R2
    '{A_L1,  32'd7,          12'h010, A_L1, 32'd7,      4'd2},  // R2
    '{A_L0,  32'd9,          12'h002, A_L0, 32'd3,      4'd3},  // R3
    '{A_L1,  32'd8,          12'h020, A_L1, 32'd7,      4'd3},  // R3
    '{A_CMD, 32'h8060_0304,  12'h100, A_RD, entry(0),   4'd4},  // R4
    '{A_CMD, 32'h8060_0313,  12'h100, A_RD, entry(15),  4'd4},  // R4
    '{A_CMD, 32'h8060_0314,  12'h200, A_RD, entry(15),  4'd5},  // R5
    '{A_CMD, 32'h8050_0305,  12'h200, A_RD, entry(15),  4'd5},  // R5
    '{A_CMD, 32'h8060_0303,  12'h200, A_RD, entry(15),  4'd5}   // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  cl0_standby = 3'b101;
  logic [1:0]  cl1_standby = 2'b11;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_req_ctrl #(.LATENCY(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cl0_standby(cl0_standby), .cl1_standby(cl1_standby), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WDOG) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (LAT + 1) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", 32'(irq_o), 32'd0);
    rd(A_L0, v); check("R1 lvl0", v, 32'd0);
    rd(A_L1, v); check("R1 lvl1", v, 32'd0);
    rd(A_WK, v); check("R1 wake", v, 32'd0);
    rd(A_ST, v); check("R1 status", v, 32'd0);

    // table-driven requests: R2 R3 R4 R5 with R7 R8 on each
    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VECS[i].req, i);
      wr(VECS[i].addr, VECS[i].wdata);
      settle();
      check({tg, " R8 irq"}, 32'(irq_o), 32'd1);
      rd(A_ST, v);
      check({tg, " status"}, v, 32'(VECS[i].exp_stat));
      check({tg, " R7 irq cleared"}, 32'(irq_o), 32'd0);
      rd(VECS[i].rb_addr, v);
      check({tg, " readback"}, v, VECS[i].exp_rb);
    end

    // R6 command without start bit
    wr(A_CMD, 32'h0060_0304);
    settle();
    check("R6 irq", 32'(irq_o), 32'd0);
    rd(A_ST, v); check("R6 status", v, 32'd0);
    rd(A_RD, v); check("R6 rdata", v, entry(15));

    // R9 second request while pending
    wr(A_L0, 32'd2);
    wr(A_L1, 32'd5);
    settle();
    rd(A_ST, v); check("R9 status", v, 32'h001);
    rd(A_L1, v); check("R9 lvl1 kept", v, 32'd7);
    rd(A_L0, v); check("R9 lvl0", v, 32'd2);

    // R8 accumulation across requests
    wr(A_L0, 32'd1);
    settle();
    wr(A_L1, 32'd0);
    settle();
    check("R8 irq held", 32'(irq_o), 32'd1);
    rd(A_ST, v); check("R8 sticky", v, 32'h011);
    rd(A_ST, v); check("R7 second read", v, 32'd0);

    // R10 wake mask
    wr(A_WK, 32'hFFFF_FFFF);
    rd(A_WK, v); check("R10 width", v, 32'h0000_0FFF);
    wr(A_WK, 32'h0000_0C00);
    rd(A_WK, v); check("R10 global", v, 32'h0000_0C00);

    // R11 standby layout
    rd(A_SB, v); check("R11 standby", v, 32'h0000_001D);
    cl0_standby = 3'b010; cl1_standby = 2'b10;
    rd(A_SB, v); check("R11 standby b", v, 32'h0000_0012);

    // R12 unmapped and command reads
    rd(8'h1C, v); check("R12 unmapped", v, 32'd0);
    rd(A_CMD, v); check("R12 cmd", v, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule